// File: doc/BRIEF.md
# EPROM Margin-Mode Programming Sequencer

This block writes a contiguous range of bytes into a byte-wide UV or one-time-programmable EPROM. It uses a verify-driven pulse algorithm. When software or a host engine raises `start_i`, the block captures an inclusive address range. It first turns on the program-voltage and margin-mode enables and waits for them to settle. It then works through the range in ascending order. For each byte it runs a loop of four steps:

- drive address and data;
- apply one program pulse on chip enable;
- hold address and data;
- read the cell back with output enable low.

A byte that reads back correctly moves the sequencer to the next address at once, with no extra overprogram pulses. A byte that is still wrong after the pulse limit stops the run. The block then latches the failing address and the last byte read back.

The byte to write comes from a source port that is read by address: `src_addr_o` selects it, and `src_data_i` must return it in the same cycle. All analog timing is counted in clock cycles:

- setup, hold and supply settling waits;
- program pulse width;
- read-back access delay.

A single down-counting timer serves every wait. When the whole range has passed, margin mode and the program voltage are removed, and the block pulses `done_o`. It then raises a level request for the final check of all bytes at two supply levels. That check is performed elsewhere.

Top module: `eprom_prog_seq`

## Requirements
- R1: During and after reset the block is idle: `mem_ce_no`=1, `mem_oe_no`=1, `mem_vpp_en_o`=0, `mem_margin_o`=0, `mem_data_oe_o`=0, `busy_o`=0, `done_o`=0, `fail_o`=0, `final_check_req_o`=0.
- R2: Timing of the supply enables:
  - A start is sampled high while idle. From the next cycle, `mem_vpp_en_o` and `mem_margin_o` are 1 and `busy_o` is 1.
  - After SETTLE_CYC cycles the first byte setup begins.
  - Both enables stay 1 through the last recovery wait of the last byte, and are 1 whenever data is driven.
- R3: Setup and hold of address and data:
  - Before each pulse, address and data are driven (`mem_data_oe_o`=1) with `mem_ce_no`=1 for SETTLE_CYC cycles.
  - After the pulse, they stay driven with `mem_ce_no`=1 for another SETTLE_CYC cycles.
  - The address does not change while `mem_ce_no` is 0.
- R4: Each program pulse holds `mem_ce_no`=0 with `mem_oe_no`=1 and data driven for exactly PULSE_CYC cycles.
- R5: Verify read:
  - After the hold, data drive is released and `mem_ce_no`=0, `mem_oe_no`=0 for VFY_CYC cycles.
  - `mem_data_i` is sampled in the last of these cycles and compared with `src_data_i`.
  - This is followed by a SETTLE_CYC-cycle recovery with both controls high and data not driven.
- R6: Retry and advance:
  - A mismatch leads to another pulse on the same address.
  - A match moves to the next address with no further pulse.
  - The pulse count restarts at zero for every byte, so a byte that needs k pulses (k ≤ MAX_PULSES) receives exactly k.
- R7: Pulse-limit failure:
  - Applies when MAX_PULSES verifies of one byte have all mismatched.
  - After the recovery wait the sequencer enters a one-cycle fail state: both supply enables 0, `fail_o`=1, `fail_addr_o`=that address, `fail_data_o`=the last byte read back.
  - It then returns to idle with `fail_o` still 1.
- R8: Completion:
  - After the last address verifies, a SETTLE_CYC margin-reset wait follows, with both enables 0 and `busy_o`=1.
  - Then `done_o` is 1 for exactly one cycle.
  - `final_check_req_o` becomes 1 in that same cycle and stays 1 while idle.
- R9: `start_i`, `first_addr_i` and `last_addr_i` are ignored while `busy_o`=1.
- R10: Addresses are visited in ascending order from the captured first to the captured last address inclusive; when they are equal, exactly one byte is programmed.
- R11: An accepted start clears `fail_o` and `final_check_req_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only while idle |
| first_addr_i | input | ADDR_W | First address of the range |
| last_addr_i | input | ADDR_W | Last address of the range (inclusive) |
| src_addr_o | output | ADDR_W | Address of the byte requested from the data source |
| src_data_i | input | DATA_W | Byte to program at `src_addr_o`, same cycle |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_data_o | output | DATA_W | Memory data bus, write direction |
| mem_data_oe_o | output | 1 | Drive enable for `mem_data_o` |
| mem_data_i | input | DATA_W | Memory data bus, read direction |
| mem_ce_no | output | 1 | Chip enable, active low (program pulse and verify) |
| mem_oe_no | output | 1 | Output enable, active low (verify) |
| mem_vpp_en_o | output | 1 | Program-voltage enable |
| mem_margin_o | output | 1 | Margin-mode enable |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-cycle pulse on successful completion |
| fail_o | output | 1 | Pulse limit hit; held until next accepted start |
| fail_addr_o | output | ADDR_W | Address that failed |
| fail_data_o | output | DATA_W | Last byte read back at the failing address |
| final_check_req_o | output | 1 | Request for the two-supply final check; held until next accepted start |

## Verification
The assertions assume two things about the inputs:

- The data source returns a byte that depends only on `src_addr_o`, so the value written and the value compared stay stable over a byte's loop.
- The captured first address never exceeds the captured last address.

The stimulus always supplies ranges in ascending order. The bench's memory model derives the source byte combinationally from the address and never produces 8'hFF for it. An unprogrammed cell reads back as 8'hFF, so it can never match the source byte by accident. Each address in the model is given a required pulse count. A start pulse with different range inputs is injected during a run. Together these drive the retry path, the exact-limit pass, the limit failure and the ignored start.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MARGIN_SET,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_NEXT,
    ST_MARGIN_RESET,
    ST_DONE,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eprom_prog_addr.sv
module eprom_prog_addr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          at_last_o
);
  logic [AW-1:0] addr_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      last_q <= '0;
    end else if (load_i) begin
      addr_q <= first_i;
      last_q <= last_i;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o    = addr_q;
  assign at_last_o = (addr_q == last_q);
endmodule

// File: rtl/eprom_prog_retry.sv
module eprom_prog_retry #(
  parameter int unsigned MAXP = 25,
  localparam int unsigned CW  = $clog2(MAXP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic limit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clear_i)                        cnt_q <= '0;
    else if (inc_i && cnt_q != CW'(MAXP))    cnt_q <= cnt_q + 1'b1;
  end

  assign limit_o = (cnt_q == CW'(MAXP));
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MAX_PULSES = 25,
  parameter int unsigned PULSE_CYC  = 1000,
  parameter int unsigned SETTLE_CYC = 20,
  parameter int unsigned VFY_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_vpp_en_o,
  output logic              mem_margin_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_data_o,
  output logic              final_check_req_o
);
  localparam int unsigned MAX_AB = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int unsigned MAXC   = (MAX_AB > VFY_CYC) ? MAX_AB : VFY_CYC;
  localparam int unsigned TW     = $clog2(MAXC + 1);

  seq_state_e        state_q, state_d;
  logic              tmr_zero, tmr_load;
  logic [TW-1:0]     tmr_val;
  logic [ADDR_W-1:0] addr;
  logic              at_last, addr_step, accept;
  logic              retry_limit, retry_inc, retry_clr;
  logic              match_q;
  logic [DATA_W-1:0] rd_q;
  logic              fail_q, fcr_q;
  logic [ADDR_W-1:0] fail_addr_q;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d   = state_q;
    addr_step = 1'b0;
    unique case (state_q)
      ST_IDLE:         if (start_i) state_d = ST_MARGIN_SET;
      ST_MARGIN_SET:   if (tmr_zero) state_d = ST_SETUP;
      ST_SETUP:        if (tmr_zero) state_d = ST_PULSE;
      ST_PULSE:        if (tmr_zero) state_d = ST_HOLD;
      ST_HOLD:         if (tmr_zero) state_d = ST_VERIFY;
      ST_VERIFY:       if (tmr_zero) state_d = ST_NEXT;
      ST_NEXT: if (tmr_zero) begin
        if (match_q) begin
          if (at_last) state_d = ST_MARGIN_RESET;
          else begin
            state_d   = ST_SETUP;
            addr_step = 1'b1;
          end
        end else if (retry_limit) state_d = ST_FAIL;
        else                      state_d = ST_SETUP;
      end
      ST_MARGIN_RESET: if (tmr_zero) state_d = ST_DONE;
      ST_DONE:         state_d = ST_IDLE;
      ST_FAIL:         state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  // every state entry reloads the shared timer with its length minus one
  always_comb begin
    unique case (state_d)
      ST_MARGIN_SET, ST_SETUP, ST_HOLD,
      ST_NEXT, ST_MARGIN_RESET: tmr_val = TW'(SETTLE_CYC - 1);
      ST_PULSE:                 tmr_val = TW'(PULSE_CYC - 1);
      ST_VERIFY:                tmr_val = TW'(VFY_CYC - 1);
      default:                  tmr_val = '0;
    endcase
  end
  assign tmr_load = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  eprom_prog_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  eprom_prog_addr #(.AW(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .load_i(accept), .first_i(first_addr_i), .last_i(last_addr_i),
    .step_i(addr_step), .addr_o(addr), .at_last_o(at_last)
  );

  assign retry_inc = (state_q == ST_SETUP) && tmr_zero;
  assign retry_clr = accept || addr_step;

  eprom_prog_retry #(.MAXP(MAX_PULSES)) u_retry (
    .clk_i, .rst_ni, .clear_i(retry_clr), .inc_i(retry_inc), .limit_o(retry_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      match_q <= 1'b0;
    end else if (state_q == ST_VERIFY && tmr_zero) begin
      rd_q    <= mem_data_i;
      match_q <= (mem_data_i == src_data_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fcr_q       <= 1'b0;
      fail_addr_q <= '0;
    end else if (accept) begin
      fail_q <= 1'b0;
      fcr_q  <= 1'b0;
    end else begin
      if (state_d == ST_FAIL && state_q != ST_FAIL) begin
        fail_q      <= 1'b1;
        fail_addr_q <= addr;
      end
      if (state_d == ST_DONE) fcr_q <= 1'b1;
    end
  end

  assign src_addr_o        = addr;
  assign mem_addr_o        = addr;
  assign mem_data_o        = src_data_i;
  assign mem_data_oe_o     = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_ce_no         = !((state_q == ST_PULSE) || (state_q == ST_VERIFY));
  assign mem_oe_no         = (state_q != ST_VERIFY);
  assign mem_vpp_en_o      = (state_q == ST_MARGIN_SET) || (state_q == ST_SETUP) ||
                             (state_q == ST_PULSE) || (state_q == ST_HOLD) ||
                             (state_q == ST_VERIFY) || (state_q == ST_NEXT);
  assign mem_margin_o      = mem_vpp_en_o;
  assign busy_o            = (state_q != ST_IDLE);
  assign done_o            = (state_q == ST_DONE);
  assign fail_o            = fail_q;
  assign fail_addr_o       = fail_addr_q;
  assign fail_data_o       = rd_q;
  assign final_check_req_o = fcr_q;

  assert_drive_needs_vpp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_data_oe_o |-> (mem_vpp_en_o && mem_margin_o));

  assert_addr_stable_ce_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> $stable(mem_addr_o));

  assert_no_bus_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && !mem_data_oe_o));

  assert_fail_drops_vpp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (!mem_vpp_en_o && !mem_margin_o && !done_o));

  assert_done_with_request_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (final_check_req_o && !mem_vpp_en_o && !fail_o));

  assert_addr_ascends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      ($stable(mem_addr_o) || (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))));
endmodule

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MAXP = 25;
  localparam int PULSE = 5;
  localparam int SETTLE = 3;
  localparam int VFY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] first_a = '0, last_a = '0;
  logic [AW-1:0] src_a, m_addr, f_addr;
  logic [DW-1:0] src_d, m_wd, m_rd, f_data;
  logic m_doe, m_ce_n, m_oe_n, m_vpp, m_mg, busy, done, fail, fcr;

  int vectors = 0;
  int errors = 0;
  int need [16];
  int pulses [16];
  int base [16];
  bit model_on = 1'b0;

  logic e_ce, e_oe, e_vpp, e_drv, e_busy, e_done, e_fail, e_fcr, e_chk_addr;
  logic [AW-1:0] e_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] src_byte(logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = a * 16'd29 + 16'd3;
    return t[7:0] & 8'h7F;
  endfunction

  assign src_d = src_byte(src_a);

  initial for (int i = 0; i < 16; i++) pulses[i] = 0;
  always @(posedge m_ce_n) if (m_doe && m_vpp) pulses[m_addr[3:0]] = pulses[m_addr[3:0]] + 1;

  always_comb begin
    if (!m_ce_n && !m_oe_n)
      m_rd = ((pulses[m_addr[3:0]] - base[m_addr[3:0]]) >= need[m_addr[3:0]]) ? src_byte(m_addr) : 8'hFF;
    else
      m_rd = 8'h00;
  end

  eprom_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .MAX_PULSES(MAXP),
    .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .VFY_CYC(VFY)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .first_addr_i(first_a), .last_addr_i(last_a),
    .src_addr_o(src_a), .src_data_i(src_d),
    .mem_addr_o(m_addr), .mem_data_o(m_wd), .mem_data_oe_o(m_doe), .mem_data_i(m_rd),
    .mem_ce_no(m_ce_n), .mem_oe_no(m_oe_n), .mem_vpp_en_o(m_vpp), .mem_margin_o(m_mg),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_addr_o(f_addr), .fail_data_o(f_data), .final_check_req_o(fcr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    chk("R4", "mem_ce_no", 32'(m_ce_n), 32'(e_ce));
    chk("R5", "mem_oe_no", 32'(m_oe_n), 32'(e_oe));
    chk("R2", "mem_vpp_en_o", 32'(m_vpp), 32'(e_vpp));
    chk("R2", "mem_margin_o", 32'(m_mg), 32'(e_vpp));
    chk("R3", "mem_data_oe_o", 32'(m_doe), 32'(e_drv));
    chk("R9", "busy_o", 32'(busy), 32'(e_busy));
    chk("R8", "done_o", 32'(done), 32'(e_done));
    chk("R7", "fail_o", 32'(fail), 32'(e_fail));
    chk("R11", "final_check_req_o", 32'(fcr), 32'(e_fcr));
    if (e_chk_addr) chk("R10", "mem_addr_o", 32'(m_addr), 32'(e_addr));
    if (e_drv) chk("R3", "mem_data_o", 32'(m_wd), 32'(src_byte(e_addr)));
  end

  // one expected phase: n cycles with fixed controls
  task automatic phase(input int n, input logic ce, input logic oe, input logic vpp,
                       input logic drv, input logic bsy, input logic dn, input logic ca);
    for (int i = 0; i < n; i++) begin
      e_ce = ce; e_oe = oe; e_vpp = vpp; e_drv = drv;
      e_busy = bsy; e_done = dn; e_chk_addr = ca;
      @(posedge clk); #1;
    end
  endtask

  task automatic run(input logic [AW-1:0] fa, input logic [AW-1:0] la, input bit poke);
    bit failed;
    failed = 1'b0;
    for (int i = 0; i < 16; i++) base[i] = pulses[i];
    first_a = fa; last_a = la; start = 1'b1;
    phase(1, 1, 1, 0, 0, 0, 0, 0);
    start = 1'b0;
    e_fail = 1'b0; e_fcr = 1'b0;          // R11
    phase(SETTLE, 1, 1, 1, 0, 1, 0, 0);   // R2 margin set
    for (int a = int'(fa); a <= int'(la) && !failed; a++) begin
      e_addr = AW'(a);
      for (int p = 1; p <= MAXP; p++) begin
        if (poke && a == int'(fa) && p == 1) begin
          start = 1'b1; first_a = 16'h0F00; last_a = 16'h0F0F;  // R9 ignored
          phase(1, 1, 1, 1, 1, 1, 0, 1);
          start = 1'b0;
          phase(SETTLE - 1, 1, 1, 1, 1, 1, 0, 1);
        end else begin
          phase(SETTLE, 1, 1, 1, 1, 1, 0, 1);  // R3 setup
        end
        phase(PULSE, 0, 1, 1, 1, 1, 0, 1);     // R4
        phase(SETTLE, 1, 1, 1, 1, 1, 0, 1);    // R3 hold
        phase(VFY, 0, 0, 1, 0, 1, 0, 1);       // R5
        phase(SETTLE, 1, 1, 1, 0, 1, 0, 1);
        if (p >= need[a[3:0]]) break;          // R6
        if (p == MAXP) failed = 1'b1;
      end
      if (!failed) chk("R6", "pulses per byte", 32'(pulses[a[3:0]] - base[a[3:0]]), 32'(need[a[3:0]]));
    end
    if (failed) begin
      e_fail = 1'b1;
      phase(1, 1, 1, 0, 0, 1, 0, 0);          // R7 fail state
      chk("R7", "fail_addr_o", 32'(f_addr), 32'(e_addr));
      chk("R7", "fail_data_o", 32'(f_data), 32'hFF);
      chk("R7", "pulses at limit", 32'(pulses[e_addr[3:0]] - base[e_addr[3:0]]), 32'(MAXP));
    end else begin
      phase(SETTLE, 1, 1, 0, 0, 1, 0, 0);     // R8 margin reset
      e_fcr = 1'b1;
      phase(1, 1, 1, 0, 0, 1, 1, 0);          // R8 done
    end
    phase(4, 1, 1, 0, 0, 0, 0, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin need[i] = (i % 4) + 1; base[i] = 0; end
    e_fail = 0; e_fcr = 0; e_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ce", 32'(m_ce_n), 1); chk("R1", "oe", 32'(m_oe_n), 1);
    chk("R1", "vpp", 32'(m_vpp), 0); chk("R1", "margin", 32'(m_mg), 0);
    chk("R1", "drive", 32'(m_doe), 0); chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0); chk("R1", "fail", 32'(fail), 0);
    chk("R1", "fcr", 32'(fcr), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    model_on = 1'b1;
    run(16'd2, 16'd6, 1'b0);                  // R10 range with retries
    need[9] = 3;
    run(16'd9, 16'd9, 1'b1);                  // R10 single byte, R9 poke
    need[12] = MAXP; need[13] = MAXP + 1;
    run(16'd12, 16'd14, 1'b0);                // R7 limit; exact-limit pass
    need[0] = 1; need[1] = 2;
    run(16'd0, 16'd1, 1'b0);                  // R11 fail cleared
    model_on = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule